// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block produces the maintenance traffic for a one-megabit, one-bit-wide dynamic memory. Once reset is released it counts out a programmed power-up pause. It then runs a fixed number of wake-up cycles. From then on it keeps a steady stream of refreshes going, so that every row is revisited within the retention window. With the default numbers, 512 rows must be covered in 8 ms, so one refresh falls due roughly every 15.6 µs.

A refresh is issued either as a CAS-before-RAS cycle or as a RAS-only cycle. In a CAS-before-RAS cycle the memory generates the row itself. In a RAS-only cycle CAS stays high and the block puts its own 9-bit row counter on the address pins. The block shares the strobes with the normal access controller. It raises a request, and while it holds the grant it drives RAS and CAS directly. If the grant is late, the refreshes that fall due in the meantime are counted up to a small limit and then issued back to back. The ready output tells the access controller when normal service may begin.

Top module: `dram_refresh_seq`

## Requirements
- R1: While rst_ni is low: ras_n_o and cas_n_o are 1, bus_req_o and ready_o are 0, and addr_o is 0.
- R2: bus_req_o stays 0 for the first PAUSE_CYC-1 clock edges after reset release and is 1 after edge PAUSE_CYC. No strobe moves before that.
- R3: Exactly INIT_CYCLES refresh cycles (RAS falling edges) happen while ready_o is 0. ready_o rises after the precharge of the last of them and then stays 1 until reset.
- R4: With ras_only_i = 0 at cycle start (CAS-before-RAS), CAS falls CAS_LEAD_CYC cycles before RAS when it was high before. CAS stays low for the whole RAS-low interval.
- R5: Every RAS-low interval lasts exactly RAS_LOW_CYC cycles. RAS stays high for at least RP_CYC cycles between two low intervals.
- R6: With ras_only_i = 1 at cycle start (RAS-only), cas_n_o stays 1. addr_o carries the row counter and is stable while RAS is low.
- R7: The row counter starts at 0 and advances by one after each RAS-only cycle, wrapping from 2^ROW_W-1 (511) to 0. CAS-before-RAS cycles leave it unchanged.
- R8: After ready_o rises, one refresh becomes owed every REF_INTERVAL cycles. bus_req_o is 1 while any refresh is owed.
- R9: The owed count saturates at PEND_MAX; ticks beyond that are dropped. With the grant held, the owed refreshes are issued back to back.
- R10: Consecutive CAS-before-RAS refreshes in one grant keep CAS low between them, so CAS falls once per burst and only RAS cycles.
- R11: bus_gnt_i is looked at only when a cycle starts. A started cycle runs to completion even if the grant is withdrawn. No strobe falls unless the grant was present. Both strobes are high whenever bus_req_o is 0.
- R12: An interval tick in the same cycle as a refresh start is still counted, so neither the new owed refresh nor the issued one is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_only_i | input | 1 | Refresh style: 1 = RAS-only with internal row, 0 = CAS-before-RAS |
| bus_gnt_i | input | 1 | Strobe ownership granted by the access controller |
| bus_req_o | output | 1 | Request for strobe ownership |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| addr_o | output | ROW_W | Row address for RAS-only refresh |
| ready_o | output | 1 | Power-up sequence done; normal accesses allowed |

## Verification
An interval tick and the acceptance of a refresh can land in the same cycle. The owed count then has to add one and remove one at once. The bench provokes this by letting exactly one refresh become owed, then raising the grant in the last cycle of an interval, so the start is accepted on the very edge where the next tick arrives. It judges the result by counting RAS falling edges over the following interval: two must appear. A lost tick or a lost decrement shows up as one or three.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_CAS_LEAD,
    ENG_RAS_ACT,
    ENG_PRECH
  } eng_state_e;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_INIT,
    PH_RUN
  } phase_e;
endpackage

// File: rtl/dref_tick_gen.sv
module dref_tick_gen #(
  parameter int unsigned PERIOD = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dref_row_ctr.sv
module dref_row_ctr #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  // natural wrap at 2^ROW_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;
endmodule

// File: rtl/dref_engine.sv
module dref_engine
  import dref_pkg::*;
#(
  parameter int unsigned CAS_LEAD_CYC = 2,
  parameter int unsigned RAS_LOW_CYC  = 13,
  parameter int unsigned RP_CYC       = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ras_only_i,
  input  logic cont_i,
  output logic accept_o,
  output logic idle_o,
  output logic row_step_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned MAX_AB = (CAS_LEAD_CYC > RAS_LOW_CYC) ? CAS_LEAD_CYC : RAS_LOW_CYC;
  localparam int unsigned MAX_C  = (MAX_AB > RP_CYC) ? MAX_AB : RP_CYC;
  localparam int unsigned CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] LEAD_LD = CW'(CAS_LEAD_CYC - 1);
  localparam logic [CW-1:0] RLOW_LD = CW'(RAS_LOW_CYC - 1);
  localparam logic [CW-1:0] RP_LD   = CW'(RP_CYC - 1);

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          rasonly_q;
  logic          cas_hold_q;
  logic          last;

  assign last       = (cnt_q == '0);
  assign idle_o     = (state_q == ENG_IDLE);
  // a RAS-only start waits one cycle while CAS is still held from a CBR burst
  assign accept_o   = idle_o && start_i && !(cas_hold_q && ras_only_i);
  assign row_step_o = (state_q == ENG_RAS_ACT) && last && rasonly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ENG_IDLE;
      cnt_q      <= '0;
      rasonly_q  <= 1'b0;
      cas_hold_q <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (accept_o) begin
            rasonly_q <= ras_only_i;
            if (ras_only_i || cas_hold_q) begin
              state_q <= ENG_RAS_ACT;
              cnt_q   <= RLOW_LD;
            end else begin
              state_q <= ENG_CAS_LEAD;
              cnt_q   <= LEAD_LD;
            end
          end else begin
            cas_hold_q <= 1'b0;
          end
        end
        ENG_CAS_LEAD: begin
          if (last) begin
            state_q <= ENG_RAS_ACT;
            cnt_q   <= RLOW_LD;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ENG_RAS_ACT: begin
          if (last) begin
            state_q    <= ENG_PRECH;
            cnt_q      <= RP_LD;
            cas_hold_q <= !rasonly_q && cont_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ENG_PRECH: begin
          if (last) begin
            state_q    <= ENG_IDLE;
            cas_hold_q <= cas_hold_q && cont_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  assign ras_n_o = !(state_q == ENG_RAS_ACT);
  assign cas_n_o = !((state_q == ENG_CAS_LEAD) ||
                     ((state_q == ENG_RAS_ACT) && !rasonly_q) ||
                     cas_hold_q);
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dref_pkg::*;
#(
  parameter int unsigned PAUSE_CYC    = 25000,
  parameter int unsigned INIT_CYCLES  = 8,
  parameter int unsigned REF_INTERVAL = 1950,
  parameter int unsigned PEND_MAX     = 4,
  parameter int unsigned CAS_LEAD_CYC = 2,
  parameter int unsigned RAS_LOW_CYC  = 13,
  parameter int unsigned RP_CYC       = 8,
  parameter int unsigned ROW_W        = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_only_i,
  input  logic             bus_gnt_i,
  output logic             bus_req_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic [ROW_W-1:0] addr_o,
  output logic             ready_o
);
  localparam int unsigned PW = $clog2(PEND_MAX + 1);
  localparam int unsigned IW = (INIT_CYCLES > 0) ? $clog2(INIT_CYCLES + 1) : 1;
  localparam logic [PW-1:0] PEND_LIM  = PW'(PEND_MAX);
  localparam logic [IW-1:0] INIT_LOAD = IW'(INIT_CYCLES);

  phase_e        phase_q;
  logic [IW-1:0] init_left_q;
  logic [PW-1:0] pend_q;
  logic          pause_tick, ref_tick;
  logic          want, start, cont, accept, eng_idle, row_step;

  dref_tick_gen #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (phase_q == PH_PAUSE),
    .tick_o(pause_tick)
  );

  dref_tick_gen #(.PERIOD(REF_INTERVAL)) u_interval (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (phase_q == PH_RUN),
    .tick_o(ref_tick)
  );

  always_comb begin
    unique case (phase_q)
      PH_INIT: want = (init_left_q != '0);
      PH_RUN:  want = (pend_q != '0);
      default: want = 1'b0;
    endcase
  end

  assign start = want && bus_gnt_i;
  // evaluated on the owed count after the current cycle's decrement
  assign cont  = want && bus_gnt_i && !ras_only_i;

  dref_engine #(
    .CAS_LEAD_CYC(CAS_LEAD_CYC),
    .RAS_LOW_CYC (RAS_LOW_CYC),
    .RP_CYC      (RP_CYC)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .ras_only_i(ras_only_i),
    .cont_i    (cont),
    .accept_o  (accept),
    .idle_o    (eng_idle),
    .row_step_o(row_step),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o)
  );

  dref_row_ctr #(.ROW_W(ROW_W)) u_row (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(row_step),
    .row_o (addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_PAUSE;
      init_left_q <= INIT_LOAD;
    end else begin
      unique case (phase_q)
        PH_PAUSE: if (pause_tick) phase_q <= PH_INIT;
        PH_INIT: begin
          if (accept) init_left_q <= init_left_q - 1'b1;
          if (init_left_q == '0 && eng_idle) phase_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (phase_q == PH_RUN) begin
      unique case ({ref_tick, accept})
        2'b10:   if (pend_q != PEND_LIM) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign bus_req_o = want || !eng_idle;
  assign ready_o   = (phase_q == PH_RUN);
endmodule

// File: rtl/dref_checker.sv
module dref_checker #(
  parameter int unsigned RAS_LOW_CYC = 13,
  parameter int unsigned RP_CYC      = 8,
  parameter int unsigned ROW_W       = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bus_gnt_i,
  input logic             bus_req_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic [ROW_W-1:0] addr_o,
  input logic             ready_o
);
  localparam int unsigned CW = $clog2(RAS_LOW_CYC + RP_CYC + 2);
  localparam logic [CW-1:0] SAT = {CW{1'b1}};

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= CW'(RP_CYC);
    end else if (ras_n_o) begin
      lo_cnt <= '0;
      if (hi_cnt != SAT) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != SAT) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assert_ras_low_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == CW'(RAS_LOW_CYC)));

  assert_precharge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= CW'(RP_CYC)));

  assert_cas_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && !$past(cas_n_o)) |-> !cas_n_o);

  assert_addr_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o && $past(!ras_n_o)) |-> $stable(addr_o));

  assert_ready_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  assert_idle_strobes_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o |-> (ras_n_o && cas_n_o));

  assert_cas_fall_granted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_o) |-> $past(bus_gnt_i));

  assert_rasonly_granted_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n_o) && cas_n_o) |-> $past(bus_gnt_i));
endmodule

bind dram_refresh_seq dref_checker #(
  .RAS_LOW_CYC(RAS_LOW_CYC),
  .RP_CYC     (RP_CYC),
  .ROW_W      (ROW_W)
) u_dref_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_gnt_i(bus_gnt_i),
  .bus_req_o(bus_req_o),
  .ras_n_o  (ras_n_o),
  .cas_n_o  (cas_n_o),
  .addr_o   (addr_o),
  .ready_o  (ready_o)
);

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;
  localparam int PAUSE = 20;
  localparam int INIT  = 8;
  localparam int INTV  = 64;
  localparam int PMAX  = 3;
  localparam int LEAD  = 2;
  localparam int RLOW  = 4;
  localparam int RP    = 3;
  localparam int ROWW  = 9;
  localparam int NROW  = 1 << ROWW;

  // [7] ras_only, [6:4] ticks with grant withheld, [3:0] expected refreshes
  localparam logic [7:0] TBL [0:7] = '{8'h11, 8'h22, 8'h33, 8'h53,
                                       8'h91, 8'hA2, 8'hC3, 8'h43};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ras_only = 1'b0;
  logic gnt = 1'b1;
  logic bus_req, ras_n, cas_n, ready;
  logic [ROWW-1:0] addr;

  always #4 clk = ~clk;

  dram_refresh_seq #(
    .PAUSE_CYC(PAUSE), .INIT_CYCLES(INIT), .REF_INTERVAL(INTV), .PEND_MAX(PMAX),
    .CAS_LEAD_CYC(LEAD), .RAS_LOW_CYC(RLOW), .RP_CYC(RP), .ROW_W(ROWW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ras_only_i(ras_only), .bus_gnt_i(gnt),
    .bus_req_o(bus_req), .ras_n_o(ras_n), .cas_n_o(cas_n), .addr_o(addr), .ready_o(ready)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_cyc = 0;
  logic mode_now = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // strobe monitor
  int falls = 0, ro_falls = 0, cas_falls = 0;
  int lo_w = 0, hi_w = 1000, cas_lo_w = 0;
  int exp_row = 0, wrap_addr = -1;
  logic ras_p = 1'b1, cas_p = 1'b1, first_after_cas = 1'b0;
  logic [ROWW-1:0] addr_f = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (cas_p && !cas_n) begin
        cas_falls++;
        first_after_cas = 1'b1;
        if (mode_now) chk(1'b0, "R6 cas fell in RAS-only", 0, 1);
      end
      if (ras_p && !ras_n) begin
        falls++;
        chk(hi_w >= RP, "R5 precharge", hi_w, RP);
        if (mode_now) begin
          chk(cas_n == 1'b1, "R6 cas at ras fall", cas_n, 1);
          chk(addr == ROWW'(exp_row), "R7 row", addr, exp_row);
          if (ro_falls == NROW) wrap_addr = int'(addr);
          exp_row = (exp_row + 1) % NROW;
          ro_falls++;
        end else begin
          chk(!cas_n, "R4 cas low at ras fall", cas_n, 0);
          if (first_after_cas) chk(cas_lo_w == LEAD, "R4 lead", cas_lo_w, LEAD);
        end
        first_after_cas = 1'b0;
        addr_f = addr;
        lo_w = 1;
      end else if (!ras_p && !ras_n) begin
        lo_w++;
        if (mode_now) chk(addr == addr_f, "R6 addr stable", addr, addr_f);
        else          chk(!cas_n, "R4 cas held", cas_n, 0);
      end else if (!ras_p && ras_n) begin
        chk(lo_w == RLOW, "R5 ras low width", lo_w, RLOW);
        hi_w = 1;
      end else begin
        hi_w++;
      end
      cas_lo_w = cas_n ? 0 : cas_lo_w + 1;
      ras_p = ras_n;
      cas_p = cas_n;
    end
  end

  task automatic goto(input int off);
    do @(negedge clk); while (((cyc - rdy_cyc) % INTV) != off);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int rel, f0, cf0;
    bit bad;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n, "R1 strobes", {ras_n, cas_n}, 3);
    chk(!bus_req, "R1 req", bus_req, 0);
    chk(!ready, "R1 ready", ready, 0);
    chk(addr == '0, "R1 addr", addr, 0);

    rst_ni = 1'b1;
    rel = cyc;
    bad = 1'b0;
    while (cyc < rel + PAUSE - 1) begin
      @(negedge clk);
      if (bus_req || !ras_n || !cas_n) bad = 1'b1;
    end
    chk(!bad, "R2 quiet during pause", bad, 0);
    @(negedge clk);
    chk(bus_req, "R2 req after pause", bus_req, 1);

    while (!ready) @(negedge clk);
    rdy_cyc = cyc;
    chk(falls == INIT, "R3 init cycles before ready", falls, INIT);

    // table walk: withhold grant, then grant and count the burst
    goto(60);
    gnt = 1'b0;
    for (int i = 0; i < 8; i++) begin
      ras_only = TBL[i][7];
      mode_now = TBL[i][7];
      repeat (int'(TBL[i][6:4])) goto(0);
      goto(16);
      chk(bus_req, "R8 req while owed", bus_req, 1);
      f0 = falls;
      cf0 = cas_falls;
      gnt = 1'b1;
      goto(60);
      chk(falls - f0 == int'(TBL[i][3:0]), "R9 burst count", falls - f0, int'(TBL[i][3:0]));
      if (TBL[i][7]) chk(cas_falls == cf0, "R6 no cas", cas_falls - cf0, 0);
      else           chk(cas_falls - cf0 == 1, "R10 single cas fall", cas_falls - cf0, 1);
      gnt = 1'b0;
    end

    // R11: one-cycle grant pulse with two owed
    ras_only = 1'b0;
    mode_now = 1'b0;
    goto(0);
    goto(0);
    goto(16);
    f0 = falls;
    gnt = 1'b1;
    @(negedge clk);
    gnt = 1'b0;
    goto(60);
    chk(falls - f0 == 1, "R11 one cycle per pulse", falls - f0, 1);
    chk(cas_n, "R11 cas released", cas_n, 1);
    chk(bus_req, "R8 req with one owed", bus_req, 1);
    goto(16);
    f0 = falls;
    gnt = 1'b1;
    goto(60);
    chk(falls - f0 == 2, "R9 drain", falls - f0, 2);
    gnt = 1'b0;

    // R12: start accepted on the edge of an interval tick
    goto(0);
    goto(INTV - 1);
    f0 = falls;
    gnt = 1'b1;
    goto(60);
    chk(falls - f0 == 2, "R12 tick with start", falls - f0, 2);
    gnt = 1'b0;

    // R7: RAS-only run across the row wrap
    ras_only = 1'b1;
    mode_now = 1'b1;
    gnt = 1'b1;
    while (ro_falls < NROW + 3) goto(60);
    chk(wrap_addr == 0, "R7 wrap to zero", wrap_addr, 0);
    chk(ready, "R3 ready held", ready, 1);
    summary();
  end
endmodule